// File: doc/BRIEF.md
# Local-History Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken by looking at the recent outcomes of that same branch. A small table of shift registers is addressed by a slice of the branch address. Each register holds the last few outcomes of whichever branch maps to it. The value of that register then selects one 2-bit saturating counter from a shared pattern table, and the upper bit of that counter is the guess.

The fetch side presents an address on the lookup port and reads the guess back in the same cycle. When the branch later completes, the back end presents its address, the real outcome and a valid strobe on the resolve port. At the next clock edge the predictor trains the counter that the old history selected, and then shifts the outcome into that branch's history. Because the guess is taken from the counter of the exact history value, every position of a short repeating loop pattern ends up with a counter of its own.

Top module: `lhist_predictor`

## Requirements
- R1: After reset every counter holds weakly taken (2'b10) and every history register holds all zeros, so every lookup predicts taken.
- R2: The history entry is chosen by the PC bits [ALIGN+IDX_W-1:ALIGN] (bits [5:2] by default). Addresses that differ only in the alignment bits or in the bits above the index share one entry.
- R3: The prediction is the upper bit of the pattern counter whose index equals the current history of the looked-up entry.
- R4: On a valid resolve, the counter selected by the history before the shift moves one step toward the outcome. It rises when the outcome is taken and falls when it is not. It stays at 2'b11 on a taken outcome and at 2'b00 on a not-taken outcome. Encoding: 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken.
- R5: On a valid resolve, the outcome (1 = taken) enters the history's least significant bit, the other bits move up by one place and the oldest bit is lost.
- R6: While the resolve valid input is low, no history and no counter changes, whatever the resolve address and outcome inputs carry.
- R7: Lookup is combinational. A resolve is seen by lookups only from the clock edge that captures it onward, so a lookup in the same cycle as a resolve to the same entry still sees the old state.
- R8: A branch that repeats the outcome pattern taken, taken, taken, not-taken is predicted correctly on every instance after a few periods of warm-up.
- R9: A counter in a strong state does not change its prediction after a single contrary outcome. From weakly not-taken, one taken outcome flips the prediction to taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_pc | input | PC_W | Address of the branch being looked up |
| pred_taken | output | 1 | Predicted direction for lk_pc (1 = taken) |
| rs_valid | input | 1 | A resolved branch is present this cycle |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome of the resolved branch (1 = taken) |

## Verification
The bench first drives the four-iteration loop pattern through one branch. A design that indexed the counters with the history after the shift, or that shifted from the wrong end, would keep missing one position of that loop. Directed sequences walk a counter to both rails and back. They show that a lost saturation check wraps 11 to 00 and reverses a strong prediction, and that a missing hysteresis state flips on a single outcome. Further cases cover addresses that alias through the alignment and upper bits, lookups made in the same cycle as a resolve, and cycles where a resolve is presented without its valid strobe. A long pseudo-random stream over all sixteen entries is then compared against an arithmetic model of the tables.

// File: rtl/lhp_pkg.sv
package lhp_pkg;

  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'b00,
    CTR_WEAK_NT   = 2'b01,
    CTR_WEAK_T    = 2'b10,
    CTR_STRONG_T  = 2'b11
  } ctr_e;

  localparam logic [1:0] CTR_RESET = CTR_WEAK_T;

  // one saturating step toward the observed outcome
  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
    logic [1:0] nxt;
    nxt = cur;
    if (taken) begin
      if (cur != CTR_STRONG_T) nxt = cur + 2'd1;
    end else begin
      if (cur != CTR_STRONG_NT) nxt = cur - 2'd1;
    end
    return nxt;
  endfunction

  function automatic logic ctr_dir(input logic [1:0] cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/lhp_rst_sync.sv
module lhp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/lhp_hist_table.sv
module lhp_hist_table #(
  parameter int IDX_W  = 4,
  parameter int HIST_W = 4
) (
  input  logic                               clk,
  input  logic                               srst_n,
  input  logic [IDX_W-1:0]                   lk_idx,
  input  logic [IDX_W-1:0]                   wr_idx,
  input  logic                               wr_en,
  input  logic                               wr_taken,
  output logic [HIST_W-1:0]                  lk_hist,
  output logic [HIST_W-1:0]                  wr_hist,
  output logic [(1<<IDX_W)-1:0][HIST_W-1:0]  hist_all
);
  localparam int NENT = 1 << IDX_W;

  logic [NENT-1:0][HIST_W-1:0] hist_q;
  logic [NENT-1:0][HIST_W-1:0] hist_d;
  logic [NENT-1:0]             ent_en;

  genvar e;
  generate
    for (e = 0; e < NENT; e++) begin : g_ent
      always_comb begin
        ent_en[e] = wr_en && (wr_idx == IDX_W'(e));
        hist_d[e] = {hist_q[e][HIST_W-2:0], wr_taken};
      end

      always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n)        hist_q[e] <= '0;
        else if (ent_en[e]) hist_q[e] <= hist_d[e];
      end
    end
  endgenerate

  assign lk_hist  = hist_q[lk_idx];
  assign wr_hist  = hist_q[wr_idx];
  assign hist_all = hist_q;
endmodule

// File: rtl/lhp_pattern_table.sv
module lhp_pattern_table #(
  parameter int HIST_W = 4
) (
  input  logic                              clk,
  input  logic                              srst_n,
  input  logic [HIST_W-1:0]                 lk_sel,
  input  logic [HIST_W-1:0]                 up_sel,
  input  logic                              up_en,
  input  logic                              up_taken,
  output logic [1:0]                        lk_ctr,
  output logic [(1<<HIST_W)-1:0][1:0]       ctr_all
);
  import lhp_pkg::*;

  localparam int NPAT = 1 << HIST_W;

  logic [NPAT-1:0][1:0] ctr_q;
  logic [NPAT-1:0][1:0] ctr_d;
  logic [NPAT-1:0]      ctr_en;

  genvar p;
  generate
    for (p = 0; p < NPAT; p++) begin : g_ctr
      always_comb begin
        ctr_en[p] = up_en && (up_sel == HIST_W'(p));
        ctr_d[p]  = ctr_step(ctr_q[p], up_taken);
      end

      always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n)        ctr_q[p] <= CTR_RESET;
        else if (ctr_en[p]) ctr_q[p] <= ctr_d[p];
      end
    end
  endgenerate

  assign lk_ctr  = ctr_q[lk_sel];
  assign ctr_all = ctr_q;
endmodule

// File: rtl/lhist_predictor.sv
module lhist_predictor #(
  parameter int PC_W   = 32,
  parameter int ALIGN  = 2,
  parameter int IDX_W  = 4,
  parameter int HIST_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            pred_taken,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken
);
  import lhp_pkg::*;

  localparam int NENT = 1 << IDX_W;
  localparam int NPAT = 1 << HIST_W;

  logic                         srst_n;
  logic [IDX_W-1:0]             lk_idx;
  logic [IDX_W-1:0]             rs_idx;
  logic [HIST_W-1:0]            lk_hist;
  logic [HIST_W-1:0]            rs_hist;
  logic [1:0]                   lk_ctr;
  logic [NENT-1:0][HIST_W-1:0]  hist_all;
  logic [NPAT-1:0][1:0]         ctr_all;

  assign lk_idx = lk_pc[ALIGN +: IDX_W];
  assign rs_idx = rs_pc[ALIGN +: IDX_W];

  lhp_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  lhp_hist_table #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .srst_n   (srst_n),
    .lk_idx   (lk_idx),
    .wr_idx   (rs_idx),
    .wr_en    (rs_valid),
    .wr_taken (rs_taken),
    .lk_hist  (lk_hist),
    .wr_hist  (rs_hist),
    .hist_all (hist_all)
  );

  // the counter is trained at the pre-shift history of the resolving entry
  lhp_pattern_table #(.HIST_W(HIST_W)) u_pht (
    .clk      (clk),
    .srst_n   (srst_n),
    .lk_sel   (lk_hist),
    .up_sel   (rs_hist),
    .up_en    (rs_valid),
    .up_taken (rs_taken),
    .lk_ctr   (lk_ctr),
    .ctr_all  (ctr_all)
  );

  assign pred_taken = ctr_dir(lk_ctr);
endmodule

// File: rtl/lhp_checker.sv
module lhp_checker #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 4,
  parameter int HIST_W = 4
) (
  input  logic                               clk,
  input  logic                               srst_n,
  input  logic [PC_W-1:0]                    lk_pc,
  input  logic                               pred_taken,
  input  logic                               rs_valid,
  input  logic [PC_W-1:0]                    rs_pc,
  input  logic                               rs_taken,
  input  logic [HIST_W-1:0]                  rs_hist,
  input  logic [(1<<IDX_W)-1:0][HIST_W-1:0]  hist_all,
  input  logic [(1<<HIST_W)-1:0][1:0]        ctr_all
);

  // R5: repeated resolve of one address sees its history shifted by one outcome
  p_hist_shift_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (rs_valid ##1 (rs_pc == $past(rs_pc))) |->
      (rs_hist == {$past(rs_hist[HIST_W-2:0]), $past(rs_taken)}));

  // R4: taken outcome raises a non-saturated counter by exactly one
  p_ctr_inc_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (rs_valid && rs_taken && (ctr_all[rs_hist] != 2'b11)) |=>
      (ctr_all[$past(rs_hist)] == $past(ctr_all[rs_hist]) + 2'd1));

  // R4: counters hold at the rails
  p_ctr_sat_hi_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (rs_valid && rs_taken && (ctr_all[rs_hist] == 2'b11)) |=>
      (ctr_all[$past(rs_hist)] == 2'b11));

  p_ctr_sat_lo_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (rs_valid && !rs_taken && (ctr_all[rs_hist] == 2'b00)) |=>
      (ctr_all[$past(rs_hist)] == 2'b00));

  // R6: no state moves without a valid resolve
  p_idle_state_r6: assert property (@(posedge clk) disable iff (!srst_n)
    !rs_valid |=> ($stable(hist_all) && $stable(ctr_all)));

  // R6, R7: with no resolve and a steady address the guess stays put
  p_idle_pred_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (!rs_valid ##1 $stable(lk_pc)) |-> $stable(pred_taken));

endmodule

bind lhist_predictor lhp_checker #(
  .PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)
) u_chk (
  .clk        (clk),
  .srst_n     (srst_n),
  .lk_pc      (lk_pc),
  .pred_taken (pred_taken),
  .rs_valid   (rs_valid),
  .rs_pc      (rs_pc),
  .rs_taken   (rs_taken),
  .rs_hist    (rs_hist),
  .hist_all   (hist_all),
  .ctr_all    (ctr_all)
);

// File: tb/sim_lhist_predictor.sv
module sim_lhist_predictor;
  localparam int WATCHDOG = 100000;

  logic        clk;
  logic        rst_n;
  logic [31:0] lk_pc;
  logic        pred_taken;
  logic        rs_valid;
  logic [31:0] rs_pc;
  logic        rs_taken;

  int checks = 0;
  int errors = 0;

  logic [3:0] mh [16];
  logic [1:0] mc [16];

  lhist_predictor u0 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .pred_taken(pred_taken),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int ix(input logic [31:0] pc);
    return int'((pc >> 2) & 32'hF);
  endfunction

  function automatic logic model_pred(input logic [31:0] pc);
    return mc[mh[ix(pc)]][1];
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin
      mh[i] = 4'b0000;
      mc[i] = 2'b10;
    end
  endtask

  task automatic model_update(input logic [31:0] pc, input logic t);
    logic [3:0] h;
    h = mh[ix(pc)];
    if (t && mc[h] != 2'b11) mc[h] = mc[h] + 2'd1;
    if (!t && mc[h] != 2'b00) mc[h] = mc[h] - 2'd1;
    mh[ix(pc)] = {h[2:0], t};
  endtask

  // called at a falling edge; checks the guess before the rising edge
  task automatic step(input logic [31:0] lpc, input logic v, input logic [31:0] rpc,
                      input logic t, input string tag);
    lk_pc = lpc; rs_valid = v; rs_pc = rpc; rs_taken = t;
    #1;
    check(pred_taken, model_pred(lpc), tag);
    @(posedge clk);
    if (v) model_update(rpc, t);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rs_valid = 1'b0; rs_pc = '0; rs_taken = 1'b0; lk_pc = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
  endtask

  task automatic lookup_expect(input logic [31:0] pc, input logic exp, input string tag);
    lk_pc = pc; rs_valid = 1'b0;
    #1;
    check(pred_taken, exp, tag);
    @(negedge clk);
  endtask

  initial begin
    #(WATCHDOG * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    logic        t;
    rst_n = 1'b0; rs_valid = 1'b0; rs_pc = '0; rs_taken = 1'b0; lk_pc = '0;
    do_reset();

    // R1: all entries predict taken after reset
    for (int i = 0; i < 16; i++) lookup_expect(32'(i) << 2, 1'b1, "R1 reset taken");

    // R9/R4: entry 6, history stays 0000 under not-taken outcomes
    step(32'h18, 1'b1, 32'h18, 1'b0, "R4 train");      // ctr0 10->01
    lookup_expect(32'h18, 1'b0, "R9 weak taken flips on one miss");
    step(32'h18, 1'b1, 32'h18, 1'b0, "R4 train");      // ctr0 01->00
    step(32'h18, 1'b1, 32'h18, 1'b0, "R4 train");      // ctr0 stays 00
    lookup_expect(32'h18, 1'b0, "R4 low rail");
    // entry 7 also has history 0000: one taken gives 01 (still not taken)
    step(32'h1C, 1'b1, 32'h1C, 1'b1, "R4 train");      // ctr0 00->01, hist7=0001
    lookup_expect(32'h18, 1'b0, "R4 saturate low held (00->01 not 11)");
    step(32'h20, 1'b1, 32'h20, 1'b1, "R4 train");      // entry8 hist0: ctr0 01->10
    lookup_expect(32'h18, 1'b1, "R9 weak not-taken flips on one hit");
    step(32'h24, 1'b1, 32'h24, 1'b1, "R4 train");      // ctr0 ->11
    step(32'h28, 1'b1, 32'h28, 1'b1, "R4 train");      // ctr0 stays 11
    step(32'h2C, 1'b1, 32'h2C, 1'b0, "R4 train");      // ctr0 11->10
    lookup_expect(32'h18, 1'b1, "R9 strong taken holds after one miss");
    lookup_expect(32'h1C, 1'b1, "R3 history 0001 uses fresh counter");

    // R7: same-cycle lookup sees old state
    lk_pc = 32'h18; rs_valid = 1'b1; rs_pc = 32'h18; rs_taken = 1'b0;
    #1; check(pred_taken, 1'b1, "R7 same cycle old value");
    @(posedge clk); model_update(32'h18, 1'b0); #1;
    rs_valid = 1'b0;
    #1; check(pred_taken, model_pred(32'h18), "R7 visible after edge");
    @(negedge clk);

    // R2: aliasing through alignment and upper bits (index 3)
    step(32'hABCD_000F, 1'b1, 32'h0000_000C, 1'b0, "R2 alias");
    step(32'h1234_000D, 1'b1, 32'hFFFF_FF0E, 1'b0, "R2 alias");
    step(32'h0000_000C, 1'b1, 32'h5555_0C0F, 1'b1, "R2 alias");
    for (int i = 0; i < 16; i++) step(32'hF000_0000 | (32'(i) << 2) | 32'(i & 3), 1'b0, 0, 1'b0, "R2 alias lookup");

    // R6: resolve fields toggle with valid low
    for (int i = 0; i < 16; i++) step(32'(i) << 2, 1'b0, 32'(i) << 2, i[0], "R6 ignored");
    for (int i = 0; i < 16; i++) step(32'(i) << 2, 1'b0, 0, 1'b0, "R6 state kept");

    // R8: loop pattern 1,1,1,0 on a single branch
    do_reset();
    for (int n = 0; n < 24; n++) step(32'h40, 1'b1, 32'h40, (n % 4) != 3, "R8 warm");
    for (int n = 0; n < 16; n++) begin
      t = (n % 4) != 3;
      lk_pc = 32'h40; rs_valid = 1'b0;
      #1; check(pred_taken, t, "R8 loop exact");
      step(32'h40, 1'b1, 32'h40, t, "R8 model");
    end

    // R3/R4/R5: pseudo-random sweep against the model
    do_reset();
    seed = 32'h1F2E_3D4C;
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a, b;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      a = seed;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      b = seed;
      step(a, b[31] | b[30], b, b[29] | b[28], "R3 R4 R5 sweep");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule